// File: doc/BRIEF.md
# Dual-Channel PLL Lock Detector with Indicator Selector

This block watches three single-cycle strobes in the oscillator clock domain: the reference divider output and the divider outputs of two synthesizer channels. For each channel it measures, around every reference strobe, how far the channel strobe lies from it in oscillator cycles. A pairing closer than a window of two oscillator periods counts as good. Any wider pairing, or a reference strobe with no channel strobe near it, counts as bad. A channel is declared locked once it has produced enough good reference cycles in a row. A single bad one drops the lock at once.

A single indicator output combines the two lock flags. The combination depends on a test-mode bit, the standby bit of each channel and a two-bit indicator select. In normal mode a table maps these bits to low, high, one channel's lock, or the AND of both. In test mode the same select bits route a raw signal to the indicator instead: a prescaler output, a divider strobe, the reference strobe, or an internal divide-by-2 or divide-by-4 of the oscillator clock. All outputs are registered, and reset is synchronous and active high.

Top module: `pll_lock_mon`

## Requirements
- R1: After reset, `lock1_o`, `lock2_o` and `ld_o` are low.
- R2: A reference strobe counts as in-window when the channel strobe falls in the same cycle or one cycle before or after it. An offset of two or more cycles, in either direction, is out of window.
- R3: A channel's lock flag rises at the clock edge that evaluates its fourth consecutive in-window reference strobe. It stays low after three.
- R4: A reference strobe with no channel strobe within one cycle of it is out of window. Any out-of-window evaluation clears that channel's run and drops its lock flag at the next edge.
- R5: While a channel's standby bit is 1, its lock flag reads 1 and its run count is held at zero.
- R6: Normal mode (`test_i`=0), both channels active (`sby1_i`=0, `sby2_i`=0). `sel_i`={LD1,LD2}: 00 gives low, 01 gives lock2, 10 gives lock1, 11 gives lock1 AND lock2.
- R7: Normal mode, `sby1_i`=0 and `sby2_i`=1. `sel_i` 00 gives low, 01 gives high, 10 and 11 give lock1.
- R8: Normal mode, `sby1_i`=1 and `sby2_i`=0. `sel_i` 00 gives low, 01 gives lock2, 10 gives high, 11 gives lock2.
- R9: Normal mode with both standby bits 1. `sel_i` 00 gives low and any other code gives high.
- R10: Test mode with `sby1_i`=0 and `sby2_i`=1. `sel_i` 00 gives low, 01 gives `pres2_i`, 10 gives `ch2_i`, 11 gives `ref_i`.
- R11: Test mode with `sby1_i`=1 and `sby2_i`=0. `sel_i` 00 gives the oscillator divided by 4, 01 gives `pres1_i`, 10 gives `ch1_i`, 11 gives the oscillator divided by 2.
- R12: Test mode with both standby bits equal forces `ld_o` low.
- R13: `ld_o` is registered. It shows the selected source one clock after that source is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference divider strobe |
| ch1_i | input | 1 | Channel 1 divider strobe |
| ch2_i | input | 1 | Channel 2 divider strobe |
| pres1_i | input | 1 | Channel 1 prescaler output (test routing) |
| pres2_i | input | 1 | Channel 2 prescaler output (test routing) |
| test_i | input | 1 | Test-mode select |
| sby1_i | input | 1 | Channel 1 standby |
| sby2_i | input | 1 | Channel 2 standby |
| sel_i | input | 2 | Indicator select, bit 1 = LD1, bit 0 = LD2 |
| lock1_o | output | 1 | Channel 1 lock flag |
| lock2_o | output | 1 | Channel 2 lock flag |
| ld_o | output | 1 | Multiplexed lock indicator |

## Verification
The bench targets the edges of the phase window. Offsets of ±1 must count as good and offsets of ±2 must not; a design with an off-by-one window would either lock on a sloppy loop or never lock. It also checks the third and fourth good reference cycles, where a miscounted run would flag lock one cycle early or late. A missing channel strobe must clear the run, and a design that skipped this would keep lock with a dead divider. Every standby and select combination is compared against the mode table, where a swapped row would route the wrong channel or force a constant level. The test-mode routes are checked cycle by cycle, including the internal divided clocks.

// File: rtl/pll_lock_mon_pkg.sv
package pll_lock_mon_pkg;
  typedef struct packed {
    logic       test;
    logic       sby1;
    logic       sby2;
    logic [1:0] sel;
  } ind_ctrl_t;
endpackage

// File: rtl/ldq_chan.sv
module ldq_chan #(
  parameter int WIN      = 2,
  parameter int LOCK_CNT = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ref_i,
  input  logic div_i,
  input  logic sby_i,
  output logic lock_o
);
  localparam int HW = WIN - 1;
  localparam int CW = $clog2(LOCK_CNT + 1);
  localparam int WW = $clog2(WIN);

  logic [HW-1:0] hist_q;
  logic [WW-1:0] wait_q, wait_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pass_ev, fail_ev;

  generate
    if (HW == 1) begin : g_hist1
      always_ff @(posedge clk_i) begin
        if (rst_i) hist_q <= '0;
        else       hist_q <= div_i;
      end
    end else begin : g_histn
      always_ff @(posedge clk_i) begin
        if (rst_i) hist_q <= '0;
        else       hist_q <= {hist_q[HW-2:0], div_i};
      end
    end
  endgenerate

  always_comb begin
    pass_ev = 1'b0;
    fail_ev = 1'b0;
    wait_d  = wait_q;
    if (wait_q != '0) begin
      if (div_i) begin
        pass_ev = 1'b1;
        wait_d  = '0;
      end else if (wait_q == WW'(1)) begin
        fail_ev = 1'b1;
        wait_d  = '0;
      end else begin
        wait_d = wait_q - 1'b1;
      end
    end else if (ref_i) begin
      if (div_i || (|hist_q)) pass_ev = 1'b1;
      else                    wait_d  = WW'(WIN - 1);
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (sby_i || fail_ev)                 cnt_d = '0;
    else if (pass_ev && cnt_q != CW'(LOCK_CNT)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wait_q <= '0;
      cnt_q  <= '0;
      lock_o <= 1'b0;
    end else begin
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
      lock_o <= sby_i | (cnt_d == CW'(LOCK_CNT));
    end
  end

  // R4
  fail_drops_lock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (fail_ev && !sby_i) |=> !lock_o);
  // R5
  sby_reads_locked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sby_i |=> lock_o);
  // R3
  run_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= CW'(LOCK_CNT));
  // R3
  rise_needs_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(lock_o) && !$past(sby_i)) |-> $past(pass_ev));
endmodule

// File: rtl/ldq_tclk.sv
module ldq_tclk #(
  parameter int DW = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic half_o,
  output logic quarter_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  assign half_o    = cnt_q[0];
  assign quarter_o = cnt_q[1];

  // R11
  half_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(half_o) || $past(rst_i));
endmodule

// File: rtl/ldq_sel.sv
module ldq_sel
  import pll_lock_mon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  ind_ctrl_t ctrl_i,
  input  logic      lock1_i,
  input  logic      lock2_i,
  input  logic      pres1_i,
  input  logic      pres2_i,
  input  logic      div1_i,
  input  logic      div2_i,
  input  logic      ref_i,
  input  logic      half_i,
  input  logic      quarter_i,
  output logic      ld_o
);
  logic pick;

  always_comb begin
    pick = 1'b0;
    if (!ctrl_i.test) begin
      unique case ({ctrl_i.sby1, ctrl_i.sby2})
        2'b00: case (ctrl_i.sel)
                 2'b00:   pick = 1'b0;
                 2'b01:   pick = lock2_i;
                 2'b10:   pick = lock1_i;
                 default: pick = lock1_i & lock2_i;
               endcase
        2'b01: case (ctrl_i.sel)
                 2'b00:   pick = 1'b0;
                 2'b01:   pick = 1'b1;
                 default: pick = lock1_i;
               endcase
        2'b10: case (ctrl_i.sel)
                 2'b00:   pick = 1'b0;
                 2'b10:   pick = 1'b1;
                 default: pick = lock2_i;
               endcase
        default: pick = (ctrl_i.sel != 2'b00);
      endcase
    end else begin
      unique case ({ctrl_i.sby1, ctrl_i.sby2})
        2'b01: case (ctrl_i.sel)
                 2'b00:   pick = 1'b0;
                 2'b01:   pick = pres2_i;
                 2'b10:   pick = div2_i;
                 default: pick = ref_i;
               endcase
        2'b10: case (ctrl_i.sel)
                 2'b00:   pick = quarter_i;
                 2'b01:   pick = pres1_i;
                 2'b10:   pick = div1_i;
                 default: pick = half_i;
               endcase
        default: pick = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) ld_o <= 1'b0;
    else       ld_o <= pick;
  end

  // R6
  sel_zero_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ctrl_i.test && ctrl_i.sel == 2'b00) |=> !ld_o);
  // R9
  both_sby_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ctrl_i.test && ctrl_i.sby1 && ctrl_i.sby2 && ctrl_i.sel != 2'b00) |=> ld_o);
  // R12
  test_equal_sby_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl_i.test && (ctrl_i.sby1 == ctrl_i.sby2)) |=> !ld_o);
endmodule

// File: rtl/pll_lock_mon.sv
module pll_lock_mon
  import pll_lock_mon_pkg::*;
#(
  parameter int WIN      = 2,
  parameter int LOCK_CNT = 4
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       ref_i,
  input  logic       ch1_i,
  input  logic       ch2_i,
  input  logic       pres1_i,
  input  logic       pres2_i,
  input  logic       test_i,
  input  logic       sby1_i,
  input  logic       sby2_i,
  input  logic [1:0] sel_i,
  output logic       lock1_o,
  output logic       lock2_o,
  output logic       ld_o
);
  localparam int NCH = 2;

  ind_ctrl_t        ctrl;
  logic [NCH-1:0]   div_v, sby_v, lock_v;
  logic             half, quarter;

  assign ctrl  = '{test: test_i, sby1: sby1_i, sby2: sby2_i, sel: sel_i};
  assign div_v = {ch2_i, ch1_i};
  assign sby_v = {sby2_i, sby1_i};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chan
      ldq_chan #(.WIN(WIN), .LOCK_CNT(LOCK_CNT)) u_chan (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ref_i (ref_i),
        .div_i (div_v[i]),
        .sby_i (sby_v[i]),
        .lock_o(lock_v[i])
      );
    end
  endgenerate

  assign lock1_o = lock_v[0];
  assign lock2_o = lock_v[1];

  ldq_tclk #(.DW(2)) u_tclk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .half_o   (half),
    .quarter_o(quarter)
  );

  ldq_sel u_sel (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .ctrl_i   (ctrl),
    .lock1_i  (lock_v[0]),
    .lock2_i  (lock_v[1]),
    .pres1_i  (pres1_i),
    .pres2_i  (pres2_i),
    .div1_i   (ch1_i),
    .div2_i   (ch2_i),
    .ref_i    (ref_i),
    .half_i   (half),
    .quarter_i(quarter),
    .ld_o     (ld_o)
  );
endmodule

// File: tb/pll_lock_mon_test.sv
`timescale 1ns/1ps
module pll_lock_mon_test;
  logic clk = 1'b0;
  logic rst, ref_s, ch1, ch2, pres1, pres2, test, sby1, sby2;
  logic [1:0] sel;
  logic lock1, lock2, ld;

  int n_run = 0;
  int n_bad = 0;
  int cnt1 = 0;
  int cnt2 = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pll_lock_mon uut (
    .clk_i(clk), .rst_i(rst), .ref_i(ref_s), .ch1_i(ch1), .ch2_i(ch2),
    .pres1_i(pres1), .pres2_i(pres2), .test_i(test), .sby1_i(sby1),
    .sby2_i(sby2), .sel_i(sel), .lock1_o(lock1), .lock2_o(lock2), .ld_o(ld)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_norm(input logic s1, input logic s2,
                                    input logic [1:0] m, input logic l1, input logic l2);
    if (m == 2'b00) return 1'b0;
    if (!s1 && !s2) return (m == 2'b01) ? l2 : (m == 2'b10) ? l1 : (l1 & l2);
    if (!s1 &&  s2) return (m == 2'b01) ? 1'b1 : l1;
    if ( s1 && !s2) return (m == 2'b10) ? 1'b1 : l2;
    return 1'b1;
  endfunction

  function automatic string tag_of(input logic s1, input logic s2);
    if (!s1 && !s2) return "R6";
    if (!s1 &&  s2) return "R7";
    if ( s1 && !s2) return "R8";
    return "R9";
  endfunction

  function automatic int step(input int c, input logic s, input int d, input bit miss);
    if (s) return 0;
    if (!miss && d >= -1 && d <= 1) return (c >= 4) ? 4 : c + 1;
    return 0;
  endfunction

  // one reference period of 16 cycles; reference strobe at cycle 4
  task automatic period(input int d1, input bit m1, input int d2, input bit m2, input string tag);
    bit l1, l2;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      ref_s = (c == 4);
      ch1   = !m1 && (c == 4 + d1);
      ch2   = !m2 && (c == 4 + d2);
    end
    @(negedge clk);
    ref_s = 0; ch1 = 0; ch2 = 0;
    cnt1 = step(cnt1, sby1, d1, m1);
    cnt2 = step(cnt2, sby2, d2, m2);
    l1 = sby1 || cnt1 >= 4;
    l2 = sby2 || cnt2 >= 4;
    check({tag, " lock1"}, lock1, l1);
    check({tag, " lock2"}, lock2, l2);
    check({tag_of(sby1, sby2), " ld"}, ld, exp_norm(sby1, sby2, sel, l1, l2));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic prev, prev2, cur, drv;
    void'($urandom(32'd9127));
    rst = 1; ref_s = 0; ch1 = 0; ch2 = 0; pres1 = 0; pres2 = 0;
    test = 0; sby1 = 0; sby2 = 0; sel = 2'b11;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 lock1", lock1, 1'b0);
    check("R1 lock2", lock2, 1'b0);
    check("R1 ld", ld, 1'b0);
    rst = 0;

    // R3: three good cycles are not enough, the fourth locks
    period(0, 0, 1, 0, "R3");
    period(-1, 0, 0, 0, "R3");
    period(1, 0, -1, 0, "R3");
    period(0, 0, 0, 0, "R3");
    period(0, 0, 0, 0, "R3");
    // R2: offset of two cycles either way is out
    period(2, 0, 0, 0, "R2");
    period(0, 0, -2, 0, "R2");
    // R4: missing channel strobe clears run
    for (int k = 0; k < 4; k++) period(0, 0, 0, 0, "R3");
    period(0, 1, 0, 0, "R4");
    period(0, 0, 3, 0, "R4");
    // R5: standby reads locked
    sby1 = 1; sel = 2'b10;
    period(3, 0, 0, 0, "R5");
    sby1 = 0;
    period(0, 0, 0, 0, "R5");

    // random periods over all normal-mode selections
    for (int k = 0; k < 120; k++) begin
      int d1, d2;
      bit m1, m2;
      if ($urandom_range(0, 7) == 0) begin
        sby1 = 1'($urandom_range(0, 1));
        sby2 = 1'($urandom_range(0, 1));
      end
      sel = 2'($urandom_range(0, 3));
      d1 = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 6)) - 3 : int'($urandom_range(0, 2)) - 1;
      d2 = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 6)) - 3 : int'($urandom_range(0, 2)) - 1;
      m1 = ($urandom_range(0, 15) == 0);
      m2 = ($urandom_range(0, 15) == 0);
      period(d1, m1, d2, m2, "R2");
    end

    // test-mode routing, ld_o follows the source one clock later (R13)
    test = 1;
    for (int g = 0; g < 4; g++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        {sby1, sby2} = 2'(g);
        sel = 2'(s);
        prev = 0; prev2 = 0; drv = 0;
        for (int t = 0; t < 24; t++) begin
          @(negedge clk);
          cur = ld;
          if (t > 0) begin
            if (g == 0 || g == 3) check("R12", cur, 1'b0);
            else if (g == 1) begin
              if (s == 0) check("R10", cur, 1'b0);
              else        check("R13 R10", cur, drv);
            end else begin
              if (s == 0 && t > 2)      check("R11 div4", cur, ~prev2);
              else if (s == 3 && t > 1) check("R11 div2", cur, ~prev);
              else if (s == 1 || s == 2) check("R13 R11", cur, drv);
            end
          end
          prev2 = prev; prev = cur;
          drv = 1'($urandom_range(0, 1));
          pres1 = 0; pres2 = 0; ch1 = 0; ch2 = 0; ref_s = 0;
          case (g * 4 + s)
            5: pres2 = drv;
            6: ch2 = drv;
            7: ref_s = drv;
            9: pres1 = drv;
            10: ch1 = drv;
            default: begin
              pres1 = drv; pres2 = drv; ref_s = drv; ch1 = drv; ch2 = drv;
            end
          endcase
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule